// File: doc/BRIEF.md
# GPIO Pin Controller with Grouped Interrupts

This block is a register-mapped controller for a parameterised bank of general-purpose pins (64 by default). Each pin owns one 32-bit word that holds its output data, a 3-bit mode, a function select and some pad settings. The mode field sets the direction and the interrupt trigger together. One value means output. Five values mean input with a given trigger. One value means input with interrupts off. The function select gives the pin to plain GPIO or to one of three peripheral functions. The pad settings are only stored.

Each pin's interrupt is steered into one of up to eight groups. Every group has pending words covering 32 pins each. Writing 1 to a bit clears it. Each group drives one interrupt line. Pin inputs pass through a two-flop synchroniser before any detection. Edges are found by comparing the synchronised sample with the previous one. The bus is a single-cycle request port. Read data is registered and appears on the cycle after the request.

Top module: `gpio_pinmux_ctrl`

## Requirements
- R1: After reset every pin word reads 0x0000000E (input, interrupts off), every pending word reads 0, and all `irq_o` and `gpio_oe_o` bits are 0.
- R2: Pin n's word sits at byte offset 4*n. Its fields are: data at bit 0, mode at bits 3:1, function at bits 6:5, pull at bits 8:7, input enable at bit 9, pad strength at bits 11:10 and 23:22, Schmitt at bit 15, group at bits 18:16, and lock at bit 21. Other bits read 0, and writes to them are dropped.
- R3: When a pin's mode is not 1, bit 0 of a read returns the pin input after the two-flop synchroniser. In mode 1 it returns the stored data bit.
- R4: `gpio_o[n]` follows the stored data bit. `gpio_oe_o[n]` is 1 only when the mode is 1 and the function is 0. `func_o[2n+1:2n]` carries the function field (0 GPIO, 1 to 3 peripherals).
- R5: The modes that set a pin's pending flag are: 2 (input high), 3 (input low), 4 (rising edge), 5 (falling edge) and 6 (either edge). Modes 0, 1 and 7 never set it.
- R6: The pending word for group g and word w is at byte offset 0x800 + 0x40*g + 4*w. Bit b shows the flag of pin 32*w+b when that pin's group field equals g, and reads 0 otherwise.
- R7: Writing 1 to a bit of a pending word clears that pin's flag, and writing 0 leaves it unchanged. If a new trigger arrives in the same cycle as the clear, the flag stays set. A level trigger that is still active keeps the flag set.
- R8: `irq_o[g]` is high when at least one pin in group g has its flag set and a mode from 2 to 6. Mode 7 masks the line but leaves the flag readable.
- R9: While bit 21 of a pin word is 1, writes change only bit 0. Only reset clears the lock.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. `rdata_o` updates on the cycle after a read request and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | NUM_PINS | Raw pin inputs |
| gpio_o | output | NUM_PINS | Output data per pin |
| gpio_oe_o | output | NUM_PINS | Output enable per pin |
| func_o | output | 2*NUM_PINS | Function select per pin |
| irq_o | output | NUM_GROUPS | Interrupt line per group |

## Verification
The hardest case to reach from the ports is a clear write landing on the same edge as a new trigger. The bench counts the synchroniser and detection registers so that a rising input's flag registers on exactly the edge the clear commits. It then checks that the flag survives. A second case is a masked pin whose flag stays readable while its group line is low. Randomised configuration writes, lock bits and input patterns exercise the field mask, the lock rule and the live input read-back against a bench model.

// File: rtl/gpio_pinmux_pkg.sv
`timescale 1ns/1ps
package gpio_pinmux_pkg;
  localparam int unsigned B_DATA    = 0;
  localparam int unsigned B_MODE_LO = 1;
  localparam int unsigned B_FUNC_LO = 5;
  localparam int unsigned B_GRP_LO  = 16;
  localparam int unsigned B_LOCK    = 21;

  localparam logic [31:0] CFG_WMASK = 32'h00E7_8FEF;
  localparam logic [31:0] CFG_RST   = 32'h0000_000E;
  localparam logic [31:0] STAT_BASE = 32'h0000_0800;

  typedef enum logic [2:0] {
    MODE_RSVD   = 3'd0,
    MODE_OUT    = 3'd1,
    MODE_LVL_HI = 3'd2,
    MODE_LVL_LO = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_BOTH   = 3'd6,
    MODE_IN_OFF = 3'd7
  } pin_mode_e;

  function automatic logic mode_armed(input pin_mode_e m);
    return (m == MODE_LVL_HI) || (m == MODE_LVL_LO) || (m == MODE_RISE) ||
           (m == MODE_FALL) || (m == MODE_BOTH);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_pin_reg.sv
`timescale 1ns/1ps
module gpio_pin_reg
  import gpio_pinmux_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] cfg_o
);
  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (wr_en_i) begin
      // locked: only the data bit moves
      if (cfg_q[B_LOCK]) cfg_q <= {cfg_q[31:1], wdata_i[B_DATA]};
      else               cfg_q <= wdata_i & CFG_WMASK;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_irq_pend.sv
`timescale 1ns/1ps
module gpio_irq_pend
  import gpio_pinmux_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      sync_i,
  input  logic      prev_i,
  input  logic      clr_i,
  output logic      pend_o
);
  logic hit;
  logic pend_q;

  always_comb begin
    unique case (mode_i)
      MODE_LVL_HI: hit = sync_i;
      MODE_LVL_LO: hit = ~sync_i;
      MODE_RISE:   hit = sync_i & ~prev_i;
      MODE_FALL:   hit = ~sync_i & prev_i;
      MODE_BOTH:   hit = sync_i ^ prev_i;
      default:     hit = 1'b0;
    endcase
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | hit;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_pinmux_ctrl.sv
`timescale 1ns/1ps
module gpio_pinmux_ctrl
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 64,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_PINS-1:0]     pin_i,
  output logic [NUM_PINS-1:0]     gpio_o,
  output logic [NUM_PINS-1:0]     gpio_oe_o,
  output logic [2*NUM_PINS-1:0]   func_o,
  output logic [NUM_GROUPS-1:0]   irq_o
);
  localparam int unsigned NUM_WORDS = (NUM_PINS + 31) / 32;

  logic [31:0]         cfg_q   [NUM_PINS];
  logic [31:0]         rd_view [NUM_PINS];
  logic [2:0]          grp     [NUM_PINS];
  logic [NUM_PINS-1:0] sync_q, prev_q, pend_q, armed;

  logic [31:0] a32, soff, s_grp, s_wrd, p_sel;
  logic        pin_hit, stat_hit, wr_pin, wr_stat, rd_req;
  logic [31:0] rd_word, rdata_q;

  // decode
  assign a32      = 32'(addr_i);
  assign p_sel    = a32 >> 2;
  assign soff     = a32 - STAT_BASE;
  assign s_grp    = soff >> 6;
  assign s_wrd    = (soff >> 2) & 32'h0000_000F;
  assign pin_hit  = (a32 < STAT_BASE) && (p_sel < NUM_PINS);
  assign stat_hit = (a32 >= STAT_BASE) && (s_grp < NUM_GROUPS) && (s_wrd < NUM_WORDS);
  assign wr_pin   = req_i && we_i && pin_hit;
  assign wr_stat  = req_i && we_i && stat_hit;
  assign rd_req   = req_i && !we_i;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (pin_i),
    .sync_o (sync_q),
    .prev_o (prev_q)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_mode_e mode_n;
    logic      wen_n, clr_n;

    assign wen_n = wr_pin && (p_sel == 32'(n));

    gpio_pin_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wen_n),
      .wdata_i (wdata_i),
      .cfg_o   (cfg_q[n])
    );

    assign mode_n = pin_mode_e'(cfg_q[n][B_MODE_LO +: 3]);
    assign grp[n] = cfg_q[n][B_GRP_LO +: 3];
    assign clr_n  = wr_stat && (s_grp == 32'(grp[n])) &&
                    (s_wrd == 32'(n / 32)) && wdata_i[n % 32];

    gpio_irq_pend u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_n),
      .sync_i (sync_q[n]),
      .prev_i (prev_q[n]),
      .clr_i  (clr_n),
      .pend_o (pend_q[n])
    );

    assign armed[n]          = mode_armed(mode_n);
    assign gpio_o[n]         = cfg_q[n][B_DATA];
    assign gpio_oe_o[n]      = (mode_n == MODE_OUT) && (cfg_q[n][B_FUNC_LO +: 2] == 2'd0);
    assign func_o[2*n +: 2]  = cfg_q[n][B_FUNC_LO +: 2];
    assign rd_view[n]        = {cfg_q[n][31:1],
                                (mode_n == MODE_OUT) ? cfg_q[n][B_DATA] : sync_q[n]};
  end

  always_comb begin
    rd_word = '0;
    if (pin_hit) begin
      for (int n = 0; n < NUM_PINS; n++)
        if (p_sel == 32'(n)) rd_word = rd_view[n];
    end else if (stat_hit) begin
      for (int n = 0; n < NUM_PINS; n++)
        if ((s_wrd == 32'(n / 32)) && (s_grp == 32'(grp[n])))
          rd_word[n % 32] = pend_q[n];
    end
  end

  always_comb begin
    irq_o = '0;
    for (int n = 0; n < NUM_PINS; n++)
      if (pend_q[n] && armed[n] && (32'(grp[n]) < NUM_GROUPS))
        irq_o[grp[n]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_pinmux_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_pinmux_ctrl_chk
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 64,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned ADDR_W     = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [31:0]           cfg_q [NUM_PINS],
  input logic [NUM_PINS-1:0]   pend_q,
  input logic [NUM_PINS-1:0]   sync_q
);
  localparam int unsigned NW = (NUM_PINS + 31) / 32;

  logic [31:0] a, so;
  logic        mapped;

  assign a      = 32'(addr_i);
  assign so     = a - 32'h0000_0800;
  assign mapped = (a < 32'(4 * NUM_PINS)) ||
                  ((a >= 32'h0000_0800) && ((so >> 6) < NUM_GROUPS) &&
                   (((so >> 2) & 32'h0000_000F) < NW));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> (rdata_o == 32'd0));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  p_irq_needs_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> (irq_o == '0));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
    p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[n][B_LOCK] |=> (cfg_q[n][31:1] == $past(cfg_q[n][31:1])));

    p_idle_no_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q[n] && !mode_armed(pin_mode_e'(cfg_q[n][3:1]))) |=> !pend_q[n]);

    p_level_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cfg_q[n][3:1] == 3'd2) && sync_q[n]) |=> pend_q[n]);
  end
endmodule

bind gpio_pinmux_ctrl gpio_pinmux_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_GROUPS (NUM_GROUPS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cfg_q   (cfg_q),
  .pend_q  (pend_q),
  .sync_q  (sync_q)
);

// File: tb/gpio_pinmux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pinmux_ctrl_bench;
  import gpio_pinmux_pkg::*;

  localparam int NP = 64;
  localparam int NG = 8;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   pin_in = '0;
  logic [NP-1:0]   gpio, oe;
  logic [2*NP-1:0] func;
  logic [NG-1:0]   irq;

  always #5 clk = ~clk;

  gpio_pinmux_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG), .ADDR_W(AW)) u_gpio_pinmux_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .gpio_o(gpio),
    .gpio_oe_o(oe), .func_o(func), .irq_o(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl [NP];
  logic [31:0] rv;

  function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [31:0] d);
    if (old[21]) return {old[31:1], d[0]};
    return d & 32'h00E7_8FEF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] c, input logic in_b);
    return {c[31:1], (c[3:1] == 3'd1) ? c[0] : in_b};
  endfunction

  function automatic int stat_addr(input int g, input int w);
    return 'h800 + 'h40 * g + 4 * w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic wcfg(input int n, input logic [31:0] d);
    wr(4 * n, d);
    mdl[n] = exp_write(mdl[n], d);
  endtask

  task automatic rcfg(input string tag, input int n);
    logic [31:0] v;
    rd(4 * n, v);
    chk(tag, v, exp_read(mdl[n], pin_in[n]));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < NP; i++) mdl[i] = 32'h0000_000E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rcfg("R1 pin0 reset", 0);
    rcfg("R1 pin63 reset", 63);
    rd(stat_addr(0, 0), rv); chk("R1 stat g0w0", rv, 32'd0);
    rd(stat_addr(7, 1), rv); chk("R1 stat g7w1", rv, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 oe", oe[31:0], 32'd0);

    // R2 field mask
    wcfg(40, 32'hFFFF_FFFF);
    rcfg("R2 mask pin40", 40);
    chk("R2 mask value", mdl[40], 32'h00E7_8FEF);

    // R3 live input vs stored data
    @(negedge clk); pin_in[2] = 1'b1; settle();
    rcfg("R3 live in", 2);
    chk("R3 live bit", exp_read(mdl[2], pin_in[2]), 32'h0000_000F);
    wcfg(2, 32'h0000_0002);
    rcfg("R3 stored data", 2);

    // R4 output drive and function
    wcfg(2, 32'h0000_0003);
    chk("R4 oe gpio", {30'd0, oe[2], gpio[2]}, 32'd3);
    wcfg(2, 32'h0000_0023);
    chk("R4 periph oe off", {31'd0, oe[2]}, 32'd0);
    chk("R4 func", {30'd0, func[5:4]}, 32'd1);

    // R5 R6 R8 rising edge, group 1
    wcfg(3, 32'h0001_0008);
    @(negedge clk); pin_in[3] = 1'b1; settle();
    rd(stat_addr(1, 0), rv); chk("R6 rise g1", rv, 32'h8);
    rd(stat_addr(0, 0), rv); chk("R6 other group", rv, 32'h0);
    chk("R8 irq g1", 32'(irq), 32'h02);
    // R7 write-0 no effect, write-1 clears
    wr(stat_addr(1, 0), 32'h0);
    rd(stat_addr(1, 0), rv); chk("R7 write0", rv, 32'h8);
    wr(stat_addr(1, 0), 32'h8);
    rd(stat_addr(1, 0), rv); chk("R7 w1c", rv, 32'h0);
    chk("R8 irq cleared", 32'(irq), 32'h0);

    // R5 rising mode ignores fall
    @(negedge clk); pin_in[3] = 1'b0; settle();
    rd(stat_addr(1, 0), rv); chk("R5 rise ignores fall", rv, 32'h0);

    // R7 clear and new edge in the same cycle: edge wins
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    wr(stat_addr(1, 0), 32'h8);
    rd(stat_addr(1, 0), rv); chk("R7 race set wins", rv, 32'h8);
    wr(stat_addr(1, 0), 32'h8);
    rd(stat_addr(1, 0), rv); chk("R7 race then clear", rv, 32'h0);

    // R5 falling edge, pin 35 group 2 (word 1 bit 3)
    wcfg(35, 32'h0002_000A);
    @(negedge clk); pin_in[35] = 1'b1; settle();
    rd(stat_addr(2, 1), rv); chk("R5 fall ignores rise", rv, 32'h0);
    @(negedge clk); pin_in[35] = 1'b0; settle();
    rd(stat_addr(2, 1), rv); chk("R5 fall", rv, 32'h8);
    chk("R8 irq g2", 32'(irq), 32'h04);
    wr(stat_addr(2, 1), 32'h8);

    // R5 either edge, pin 4 group 0
    wcfg(4, 32'h0000_000C);
    @(negedge clk); pin_in[4] = 1'b1; settle();
    rd(stat_addr(0, 0), rv); chk("R5 both up", rv, 32'h10);
    wr(stat_addr(0, 0), 32'h10);
    @(negedge clk); pin_in[4] = 1'b0; settle();
    rd(stat_addr(0, 0), rv); chk("R5 both down", rv, 32'h10);
    wr(stat_addr(0, 0), 32'h10);
    rd(stat_addr(0, 0), rv); chk("R7 both clear", rv, 32'h0);

    // R7 level high stays set while active
    wcfg(6, 32'h0003_0004);
    @(negedge clk); pin_in[6] = 1'b1; settle();
    wr(stat_addr(3, 0), 32'h40);
    rd(stat_addr(3, 0), rv); chk("R7 level reasserts", rv, 32'h40);
    @(negedge clk); pin_in[6] = 1'b0; settle();
    wr(stat_addr(3, 0), 32'h40);
    rd(stat_addr(3, 0), rv); chk("R7 level released", rv, 32'h0);

    // R5 level low, then R8 mask by mode 7
    wcfg(7, 32'h0004_0006); settle();
    rd(stat_addr(4, 0), rv); chk("R5 level low", rv, 32'h80);
    chk("R8 irq g4", 32'(irq), 32'h10);
    wcfg(7, 32'h0004_000E);
    chk("R8 masked irq", 32'(irq), 32'h0);
    rd(stat_addr(4, 0), rv); chk("R8 masked flag kept", rv, 32'h80);
    @(negedge clk); pin_in[7] = 1'b1;
    wr(stat_addr(4, 0), 32'h80); settle();
    rd(stat_addr(4, 0), rv); chk("R5 mode7 no set", rv, 32'h0);

    // R9 lock
    wcfg(10, 32'h0020_0003);
    wcfg(10, 32'h0000_0040);
    rcfg("R9 locked cfg", 10);
    chk("R9 locked value", mdl[10], 32'h0020_0002);
    chk("R9 data follows", {30'd0, oe[10], gpio[10]}, 32'h2);

    // R10 unmapped
    wr('h100, 32'hFFFF_FFFF);
    rd('h100, rv); chk("R10 unmapped pin", rv, 32'h0);
    rd(stat_addr(0, 2), rv); chk("R10 unmapped word", rv, 32'h0);
    rd('hA00, rv); chk("R10 unmapped group", rv, 32'h0);
    rcfg("R10 write no effect", 63);

    // random config writes on pins 48..63
    for (int it = 0; it < 60; it++) begin
      int p;
      logic [31:0] d;
      p = 48 + int'($urandom % 16);
      d = $urandom;
      if (($urandom % 4) != 0) d[21] = 1'b0;
      @(negedge clk); pin_in[63:48] = 16'($urandom);
      wcfg(p, d);
      rcfg("R2 R3 R9 random cfg", p);
      if ((it % 4) == 0) begin
        rd('h100 + 4 * int'($urandom % 64), rv); chk("R10 random unmapped", rv, 32'h0);
        rd(stat_addr(int'($urandom % 8), 2 + int'($urandom % 14)), rv);
        chk("R10 random stat hole", rv, 32'h0);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule